// File: doc/BRIEF.md
# Keyed-Command Watchdog Timer

This block is a watchdog that counts system-clock cycles in a free-running binary counter and emits a one-cycle timeout pulse whenever a selected interval passes without software servicing it. A small register port exposes two 8-bit locations. A mode location holds an enable bit and a 3-bit interval selector. A command location accepts key bytes. One key restarts the count, and a second key stops the watchdog, but only once the enable bit has already been cleared.

Software services the watchdog by writing the restart key before each interval runs out. Turning the watchdog off takes two deliberate steps: clear the enable bit, then write the stop key. This makes an accidental shutdown by a single stray store unlikely. Writing the enable bit as 1 restarts the watchdog, with the count starting from zero. After each pulse the counter wraps to zero and keeps counting, so a program that has stopped servicing the watchdog gets a new pulse at every interval.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is running, the enable bit is 1, the interval selector is 000, the counter is zero, the mode location reads 0x80 and `timeout_o` is low.
- R2: A write to the mode location (address 0) loads the enable bit from data bit 7 and the selector from data bits 2:0. Reading the mode location returns the enable bit in bit 7, the selector in bits 2:0, and zeros in bits 6:3.
- R3: Selector code k picks an interval of T = 2^(BASE_EXP + STEP*min(k,5)) cycles, so codes 110 and 111 behave like 101. With the defaults (BASE_EXP=15, STEP=2), code 011 gives 2^21. With the counter at zero after clock edge E, the pulse is high in the cycle after edge E+T.
- R4: The timeout pulse lasts exactly one cycle. The counter restarts from zero and, without servicing, the next pulse follows T cycles later.
- R5: Writing 0x4E to the command location (address 1) sets the counter to zero. If that write lands on the edge where the interval would expire, the write takes priority and no pulse is raised.
- R6: Writing 0xB1 to the command location while the enable bit is 0 stops the watchdog. The counter is held at zero and no pulse is raised.
- R7: Writing 0xB1 while the enable bit is 1 has no effect, and pulses keep their timing.
- R8: Clearing the enable bit without a later 0xB1 write leaves the watchdog counting and pulsing.
- R9: Writing the mode location with bit 7 set starts a stopped watchdog, with the counter starting from zero at that write edge.
- R10: Any command byte other than 0x4E and 0xB1 is ignored. The mode contents, the run state and the count all stay as they were.
- R11: Reading the command location always returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that drives the counter |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr_i | input | 1 | Location select: 0 = mode, 1 = command |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected location, combinational |
| timeout_o | output | 1 | One-cycle pulse each time the interval expires |

## Verification
The bench builds the block with BASE_EXP=4, which keeps STEP=2. The intervals then become 16, 64, 256, 1024, 4096 and 16384 cycles. With these values, every selector code can be measured to the exact edge, including the repeated pulse and the saturating codes 110 and 111, all within a short run. The short intervals also make it possible to land a restart write on the exact expiry edge, to check that a stopped watchdog stays silent across several intervals, and to check that stray keys leave the interval unchanged.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned PER_W    = 3;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned EN_BIT   = 7;
    localparam logic [7:0]  KEY_RESTART = 8'h4E;
    localparam logic [7:0]  KEY_STOP    = 8'hB1;
    localparam logic        LOC_MODE = 1'b0;
    localparam logic        LOC_CMD  = 1'b1;

    typedef struct packed {
        logic             en;
        logic [PER_W-1:0] per;
        logic             run;
    } wdt_ctl_t;
endpackage

// File: rtl/wdt_keydec.sv
module wdt_keydec
    import wdt_pkg::*;
(
    input  logic              cmd_we_i,
    input  logic [DATA_W-1:0] key_i,
    input  logic              en_bit_i,
    output logic              restart_o,
    output logic              stop_o
);
    always_comb begin
        restart_o = cmd_we_i && (key_i == KEY_RESTART);
        stop_o    = cmd_we_i && (key_i == KEY_STOP) && !en_bit_i;
    end
endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_EXP = 15,
    parameter int unsigned STEP     = 2,
    parameter int unsigned CNT_W    = BASE_EXP + 5 * STEP
)(
    input  logic [PER_W-1:0] per_i,
    output logic [CNT_W-1:0] term_o
);
    localparam int unsigned NCODE   = 1 << PER_W;
    localparam int unsigned MAX_IDX = 5;

    logic [CNT_W-1:0] term_tab [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_tab
        localparam int unsigned IDX = (g > MAX_IDX) ? MAX_IDX : g;
        localparam int unsigned EXP = BASE_EXP + STEP * IDX;
        assign term_tab[g] = CNT_W'((64'd1 << EXP) - 64'd1);
    end

    assign term_o = term_tab[per_i];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 25
)(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             tmo_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tmo;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tmo = 1'b0;
        if (restart_i || !run_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= term_i) begin
            st_d.cnt = '0;
            st_d.tmo = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tmo_o = st_q.tmo;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned BASE_EXP = 15,
    parameter int unsigned STEP     = 2
)(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       bus_we_i,
    input  logic       bus_addr_i,
    input  logic [7:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o,
    output logic       timeout_o
);
    localparam int unsigned CNT_W = BASE_EXP + 5 * STEP;

    wdt_ctl_t         ctl_d, ctl_q;
    logic             cmd_we, mode_we;
    logic             restart, stop;
    logic [CNT_W-1:0] term;
    logic             mode_en, run_state;
    logic [PER_W-1:0] mode_per;

    assign cmd_we    = bus_we_i && (bus_addr_i == LOC_CMD);
    assign mode_we   = bus_we_i && (bus_addr_i == LOC_MODE);
    assign mode_en   = ctl_q.en;
    assign mode_per  = ctl_q.per;
    assign run_state = ctl_q.run;

    wdt_keydec u_keydec (
        .cmd_we_i  (cmd_we),
        .key_i     (bus_wdata_i),
        .en_bit_i  (ctl_q.en),
        .restart_o (restart),
        .stop_o    (stop)
    );

    wdt_period_sel #(
        .BASE_EXP (BASE_EXP),
        .STEP     (STEP),
        .CNT_W    (CNT_W)
    ) u_persel (
        .per_i  (ctl_q.per),
        .term_o (term)
    );

    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (ctl_q.run),
        .restart_i (restart),
        .term_i    (term),
        .tmo_o     (timeout_o)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (mode_we) begin
            ctl_d.en  = bus_wdata_i[EN_BIT];
            ctl_d.per = bus_wdata_i[PER_W-1:0];
            if (bus_wdata_i[EN_BIT]) ctl_d.run = 1'b1;
        end
        if (stop) ctl_d.run = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.en  <= 1'b1;
            ctl_q.per <= '0;
            ctl_q.run <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == LOC_MODE) begin
            bus_rdata_o[EN_BIT]      = ctl_q.en;
            bus_rdata_o[PER_W-1:0]   = ctl_q.per;
        end
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bus_we_i,
    input logic       bus_addr_i,
    input logic [7:0] bus_wdata_i,
    input logic [7:0] bus_rdata_o,
    input logic       timeout_o,
    input logic       en_bit,
    input logic [2:0] per,
    input logic       run
);
    logic cmd_wr;
    assign cmd_wr = bus_we_i && bus_addr_i;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> !timeout_o); // R4
    AST_RESTART_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && bus_wdata_i == 8'h4E) |=> !timeout_o); // R5
    AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && bus_wdata_i == 8'hB1 && !en_bit) |=> !run); // R6
    AST_HALTED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run |=> !timeout_o); // R6
    AST_STOP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && bus_wdata_i == 8'hB1 && en_bit) |=> run); // R7
    AST_ENABLE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && !bus_addr_i && bus_wdata_i[7]) |=> (run && en_bit)); // R9
    AST_OTHER_KEYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && bus_wdata_i != 8'h4E && bus_wdata_i != 8'hB1)
        |=> ($stable(run) && $stable(en_bit) && $stable(per))); // R10
    AST_CMD_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_addr_i |-> (bus_rdata_o == 8'h00)); // R11
endmodule

bind keyed_wdt wdt_checker u_wdt_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .timeout_o   (timeout_o),
    .en_bit      (mode_en),
    .per         (mode_per),
    .run         (run_state)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
    localparam int unsigned BASE = 4;
    localparam int unsigned NVEC = 8;
    localparam logic [2:0]  V_CODE [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int          V_T    [NVEC] = '{16, 64, 256, 1024, 4096, 16384, 16384, 16384};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tmo;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    keyed_wdt #(.BASE_EXP(BASE), .STEP(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .timeout_o(tmo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0; addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
        addr = 1'b0;
    endtask

    // counts edges until a pulse is seen; returns limit+1 when none appears
    task automatic edges_to_pulse(input int limit, output int n);
        n = limit + 1;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (tmo) begin n = i; break; end
        end
    endtask

    initial begin
        logic [7:0] r;
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tmo == 1'b0, "R1 tmo low in reset", tmo, 0);
        rst_n = 1'b1;
        rd(1'b0, r);
        check(r == 8'h80, "R1 mode read", r, 8'h80);
        edges_to_pulse(40, n);
        check(n == 16, "R1/R3 first pulse after reset", n, 16);

        // R3/R4: table walk over every selector code
        for (int v = 0; v < NVEC; v++) begin
            wr(1'b0, {1'b1, 4'b0, V_CODE[v]});
            wr(1'b1, 8'h4E);
            edges_to_pulse(2 * V_T[v], n);
            check(n == V_T[v], "R3 interval", n, V_T[v]);
            @(posedge clk); @(negedge clk);
            check(tmo == 1'b0, "R4 one-cycle pulse", tmo, 0);
            edges_to_pulse(2 * V_T[v], n);
            check(n == V_T[v] - 1, "R4 repeat interval", n + 1, V_T[v]);
        end

        wr(1'b0, 8'h80);
        // R2: mode layout, reserved bits read zero
        wr(1'b0, 8'h7B);
        rd(1'b0, r);
        check(r == 8'h03, "R2 mode readback reserved", r, 8'h03);
        wr(1'b0, 8'h85);
        rd(1'b0, r);
        check(r == 8'h85, "R2 mode readback", r, 8'h85);
        wr(1'b0, 8'h80);

        // R5: restart just before expiry repeatedly, no pulse
        wr(1'b1, 8'h4E);
        for (int k = 0; k < 4; k++) begin
            edges_to_pulse(13, n);
            check(n == 14, "R5 restart holds off pulse", n, 14);
            wr(1'b1, 8'h4E);
        end
        // R5: restart on the exact expiry edge wins
        wr(1'b1, 8'h4E);
        edges_to_pulse(15, n);
        check(n == 16, "R5 no pulse before expiry", n, 16);
        wr(1'b1, 8'h4E);
        check(tmo == 1'b0, "R5 restart beats expiry", tmo, 0);
        edges_to_pulse(40, n);
        check(n == 16, "R5 interval after restart", n, 16);

        // R11: command location reads zero
        rd(1'b1, r);
        check(r == 8'h00, "R11 command read", r, 0);

        // R10: stray keys do not disturb the count or the mode
        wr(1'b1, 8'h4E);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'hFF);
        wr(1'b1, 8'h4F);
        edges_to_pulse(40, n);
        check(n == 13, "R10 stray keys ignored", n + 3, 16);
        rd(1'b0, r);
        check(r == 8'h80, "R10 mode unchanged", r, 8'h80);

        // R7: stop key while enabled is ignored
        wr(1'b1, 8'h4E);
        wr(1'b1, 8'hB1);
        edges_to_pulse(40, n);
        check(n == 15, "R7 stop key ignored when enabled", n + 1, 16);

        // R8: clearing enable alone keeps running
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h4E);
        edges_to_pulse(40, n);
        check(n == 16, "R8 still running with enable 0", n, 16);

        // R6: two-step stop
        wr(1'b1, 8'hB1);
        edges_to_pulse(80, n);
        check(n == 81, "R6 stopped no pulse", n, 81);
        wr(1'b1, 8'h4E);
        edges_to_pulse(40, n);
        check(n == 41, "R6 restart key while stopped", n, 41);
        rd(1'b0, r);
        check(r == 8'h00, "R6 mode after stop", r, 0);

        // R9: re-enable starts from zero
        wr(1'b0, 8'h81);
        edges_to_pulse(100, n);
        check(n == 64, "R9 restart after enable", n, 64);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule